// File: doc/BRIEF.md
# Edge-to-Edge Pulse Width Recorder

The recorder times every high and every low stretch of one asynchronous single-bit input and writes each finished duration into an on-chip buffer. Writing needs no gap between samples. It has one free-running width counter that restarts on every detected edge. In the same clock cycle as that edge, the counter value is stored together with a tag bit that gives the level of the stretch that just ended. Software never has to subtract timer snapshots or move data between samples. At the nominal 20 MHz clock each count is 50 ns, and back-to-back stretches as short as 10 counts are recorded without loss.

A capture run starts with a one-cycle arm strobe. The input is brought through a two-stage synchronizer. The first edge seen after arming only starts the timing, and each later edge stores one entry. When the buffer holds 1000 entries, the recorder raises `done` and stops writing. A host then reads the entries through a simple address/data port that has one clock of latency. Arming again starts a new run.

Top module: `pulse_width_recorder`

## Requirements
- R1: Every interval between two consecutive detected edges, high or low, produces exactly one buffer entry, written in order from address 0. Bit 16 of the entry is the level of the interval that ended: 1 for high, 0 for low.
- R2: Bits 15:0 of an entry hold the number of clock ticks between the two detected edges that bound the interval. Back-to-back intervals of 10 ticks are all recorded, with none missing.
- R3: An interval longer than 65535 ticks is stored as 0xFFFF.
- R4: An arm strobe clears the entry count to 0 and drops `done` on the next clock. The first edge after arming writes nothing, so the partial interval before it is discarded.
- R5: `entry_count` rises by one for each entry written. `done` rises on the same clock edge that writes entry 1000, and at that point `entry_count` equals 1000. An input toggle shows up in `entry_count` three clock edges later.
- R6: While `done` is high and no new arm strobe arrives, input edges change neither `entry_count` nor any stored entry.
- R7: While `done` is high, `rd_data` shows the entry at `rd_addr` one clock after the address is applied. While `done` is low, `rd_data` holds its last value.
- R8: After reset, `done` is 0 and `entry_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, one tick per width count |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm | input | 1 | One-cycle strobe that starts a new capture run |
| sig_in | input | 1 | Asynchronous signal under test |
| rd_addr | input | 10 | Entry index to read, 0 to 999 |
| rd_data | output | 17 | Entry read: bit 16 is the level tag, bits 15:0 are the width |
| done | output | 1 | High once the buffer is full, until the next arm |
| entry_count | output | 10 | Number of entries stored in the current run |

## Verification
An input toggle passes through two synchronizer flops and then the edge register, so the write, the `entry_count` step and the rise of `done` all land on the third clock edge after the toggle. A read appears on the first clock edge after `rd_addr` changes. The bench drives inputs on falling edges and counts exactly that many falling edges before it samples: it checks that `done` is still low after two and high after three. The scoreboard queue holds one expected word per interval. The monitor compares it against a read issued one clock earlier, so any slip in latency or in the order of entries shows up as a mismatch.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_FULL = 2'd3
  } cap_state_e;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_async,
  output logic edge_o,
  output logic ended_level_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sig_async};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o        = sync_q[SYNC_STAGES-1] ^ prev_q;
  assign ended_level_o = prev_q;

  // an edge is a one-cycle event: the comparison register catches up next cycle
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (ended_level_o == $past(sync_q[SYNC_STAGES-1]))); // R1
endmodule

// File: rtl/pwr_width_ctr.sv
module pwr_width_ctr #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  output logic [WIDTH_W-1:0] width_o
);
  localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = restart_i || (cnt_q != CNT_MAX);
    cnt_d  = restart_i ? WIDTH_W'(1) : cnt_q + WIDTH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign width_o = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (width_o == CNT_MAX && !restart_i) |=> (width_o == CNT_MAX)); // R3
endmodule

// File: rtl/pwr_capture_ctl.sv
module pwr_capture_ctl
  import pwr_pkg::*;
#(
  parameter int DEPTH  = 1000,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              edge_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DEPTH - 1);

  cap_state_e       state_q, state_d;
  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    state_d = state_q;
    count_d = count_q;
    wr_en_o = 1'b0;
    if (arm_i) begin
      state_d = ST_WAIT;
      count_d = '0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (edge_i) state_d = ST_RUN;
        ST_RUN: begin
          if (edge_i) begin
            wr_en_o = 1'b1;
            count_d = count_q + CNT_W'(1);
            if (count_q == LAST_IDX) state_d = ST_FULL;
          end
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
    end
  end

  assign wr_addr_o = ADDR_W'(count_q);
  assign count_o   = count_q;
  assign full_o    = (state_q == ST_FULL);

  AST_WAIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !wr_en_o); // R4
endmodule

// File: rtl/pwr_store.sv
module pwr_store #(
  parameter int DEPTH  = 1000,
  parameter int DW     = 17,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q, rd_d;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_comb begin
    rd_d = '0;
    if (int'(rd_addr_i) < DEPTH) rd_d = mem[rd_addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R7
endmodule

// File: rtl/pulse_width_recorder.sv
module pulse_width_recorder #(
  parameter int DEPTH       = 1000,
  parameter int WIDTH_W     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int DW         = WIDTH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              sig_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  entry_count
);
  logic               rst_n_int;
  logic               edge_det;
  logic               ended_level;
  logic [WIDTH_W-1:0] width;
  logic               wr_en;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DW-1:0]      wr_word;

  pwr_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  pwr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .sig_async     (sig_in),
    .edge_o        (edge_det),
    .ended_level_o (ended_level)
  );

  pwr_width_ctr #(.WIDTH_W(WIDTH_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .restart_i (edge_det),
    .width_o   (width)
  );

  pwr_capture_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .arm_i     (arm),
    .edge_i    (edge_det),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .count_o   (entry_count),
    .full_o    (done)
  );

  assign wr_word = {ended_level, width};

  pwr_store #(.DEPTH(DEPTH), .DW(DW), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_word),
    .rd_en_i   (done),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n_int)
    entry_count <= CNT_W'(DEPTH)); // R5
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (wr_en && !arm) |=> (entry_count == $past(entry_count) + CNT_W'(1))); // R5
  AST_WIDTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_en |-> (width != '0)); // R2
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_int)
    arm |=> (entry_count == '0 && !done)); // R4
  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (done && !arm) |=> $stable(entry_count)); // R6
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |-> !wr_en); // R6
endmodule

// File: tb/pulse_width_recorder_bench.sv
module pulse_width_recorder_bench;
  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm;
  logic        sig_in;
  logic [9:0]  rd_addr;
  logic [16:0] rd_data;
  logic        done;
  logic [9:0]  entry_count;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [16:0] exp_q[$];
  logic [16:0] last_read;
  event ev_drain, ev_drained;

  always #5 clk = ~clk;

  pulse_width_recorder u_pulse_width_recorder (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sig_in(sig_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .entry_count(entry_count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sat(input int w);
    return (w > 65535) ? 16'hFFFF : 16'(w);
  endfunction

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // driver: one interval of w ticks ending with a toggle; rec pushes the expected word
  task automatic interval(input int w, input bit rec);
    repeat (w) @(negedge clk);
    if (rec) exp_q.push_back({sig_in, sat(w)});
    sig_in = ~sig_in;
  endtask

  // monitor: reads every entry with one clock of latency and pops the scoreboard
  initial begin
    forever begin
      @(ev_drain);
      for (int a = 0; a < DEPTH; a++) begin
        logic [16:0] e;
        rd_addr = 10'(a);
        @(negedge clk);
        e = exp_q.pop_front();
        chk(rd_data === e, (e[15:0] == 16'hFFFF) ? "R3 saturated entry" : "R1/R2 entry", 32'(rd_data), 32'(e));
        last_read = rd_data;
      end
      ->ev_drained;
    end
  end

  // R2 run: widths alternate levels, 10..14 ticks, with one overlong interval
  task automatic capture_run(input int pre, input int base, input int span, input int long_idx);
    pulse_arm();
    @(negedge clk);
    chk(entry_count == 0, "R4 count cleared by arm", 32'(entry_count), 0);
    chk(done == 1'b0, "R4 done cleared by arm", 32'(done), 0);
    interval(pre, 1'b0);                 // first edge: starts timing only
    for (int i = 0; i < DEPTH; i++) begin
      int w;
      w = (i == long_idx) ? 70000 : base + (i % span);
      if (i == 500) begin
        repeat (3) @(negedge clk);
        chk(entry_count == 10'd500, "R5 count mid run", 32'(entry_count), 500);
        repeat (w - 3) @(negedge clk);
        exp_q.push_back({sig_in, sat(w)});
        sig_in = ~sig_in;
      end else begin
        interval(w, 1'b1);
      end
    end
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R5 done not early", 32'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R5 done on last write", 32'(done), 1);
    chk(entry_count == 10'd1000, "R5 full count", 32'(entry_count), 1000);
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; sig_in = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", 32'(done), 0);
    chk(entry_count == 0, "R8 reset count", 32'(entry_count), 0);

    // run 1: low start, one saturating interval
    capture_run(40, 10, 5, 3);
    // R6: edges after full are ignored
    for (int k = 0; k < 5; k++) interval(12, 1'b0);
    repeat (5) @(negedge clk);
    chk(entry_count == 10'd1000, "R6 count frozen", 32'(entry_count), 1000);
    chk(done == 1'b1, "R6 done held", 32'(done), 1);
    ->ev_drain; @(ev_drained);
    chk(exp_q.size() == 0, "R1 scoreboard empty", 32'(exp_q.size()), 0);

    // run 2: high start, partial interval before first edge discarded
    interval(7, 1'b0);
    repeat (5) @(negedge clk);
    pulse_arm();
    rd_addr = 10'd0;
    repeat (2) @(negedge clk);
    chk(rd_data === last_read, "R7 read held while not done", 32'(rd_data), 32'(last_read));
    capture_run(100, 10, 3, -1);
    ->ev_drain; @(ev_drained);
    chk(exp_q.size() == 0, "R4 scoreboard empty", 32'(exp_q.size()), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule